// File: doc/BRIEF.md
# One-Time-Programmable Word Array

This block models a one-time-programmable storage array of 32-bit words inside a synthesizable design. Two streaming channels serve it. A read channel takes a byte address and a length of one to four bytes. It returns the addressed bytes packed little-endian and right-aligned, and the address need not be aligned to a word. A program channel takes a word index and a 32-bit active-low mask: each mask bit at 0 marks a bit to burn, and each bit at 1 leaves that bit alone.

Programming can only move a bit one way, and the direction depends on the parity of the word index. Even words can only gain ones. Odd words can only lose ones. A request that would leave the word equal to the inverted mask is refused. So is a request whose index lies outside the array. A refused request raises an error pulse and leaves the array untouched. Each request runs as a fixed two-cycle read-modify-write while a busy flag is high. In the second cycle the block reports the outcome, the resulting word, and a vector of targeted bits that were already burned. After reset, the array holds all zeros in even words and all ones in odd words.

Both request channels follow valid/ready rules. A request transfers on a rising edge where its valid and ready are both high. The read response is held in a one-entry slot that stays valid, with stable data, until the consumer takes it with ready. The read request ready is low while that slot is full and is not being drained. The program request ready is the inverse of busy.

Top module: `otp_array`

## Requirements
- R1: After reset, every even-indexed word reads 0x00000000 and every odd-indexed word reads 0xFFFFFFFF.
- R2: An accepted request to an even word (index bit 0 = 0) stores old | ~mask, so only 0-to-1 changes occur on targeted (mask 0) bits.
- R3: An accepted request to an odd word (index bit 0 = 1) stores old & mask, so only 1-to-0 changes occur on targeted bits.
- R4: A request is refused when old ^ ~mask equals zero. In that case pg_error pulses, pg_done stays low, pg_result shows the unchanged old word, and the array keeps its contents.
- R5: A request whose index is DEPTH or larger is refused with pg_error, and no word changes.
- R6: During the outcome cycle, pg_conflict marks the targeted bits that were already in their programmed state. For even words this is old & ~mask; for odd words it is ~old & ~mask. The vector does not affect acceptance.
- R7: Once a request is accepted, pg_busy is high for exactly two cycles. pg_done or pg_error is a one-cycle pulse in the second of those cycles, and the written word can be read from the next cycle on.
- R8: While pg_busy is high, pg_req_ready is low and any request presented is ignored.
- R9: A read of size code n (the length in bytes minus one, 0..3) at byte address a returns bytes a..a+n. Byte a sits in bits [7:0], the next byte above it, and unused upper bytes are zero. Bytes past the end of the array read as zero, and reads may cross a word boundary.
- R10: A read response stays valid with stable data until rd_rsp_ready is high. While it waits, rd_req_ready is low. The response appears the cycle after the request is accepted.
- R11: pg_done and pg_error are never high together, and neither is high outside a busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, loads the parity pattern |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request can be taken |
| rd_addr | input | log2(DEPTH)+2 | Byte address of the first byte read |
| rd_size | input | 2 | Read length in bytes minus one |
| rd_rsp_valid | output | 1 | Read response slot full |
| rd_rsp_ready | input | 1 | Consumer takes the read response |
| rd_rsp_data | output | 32 | Read bytes, little-endian, zero-filled above the length |
| pg_req_valid | input | 1 | Program request valid |
| pg_req_ready | output | 1 | Program request can be taken (engine idle) |
| pg_index | input | log2(DEPTH)+1 | Word index to program, may exceed the array |
| pg_mask | input | 32 | Active-low bit select, 0 = program this bit |
| pg_busy | output | 1 | Read-modify-write in progress |
| pg_done | output | 1 | One-cycle pulse: request accepted and written |
| pg_error | output | 1 | One-cycle pulse: request refused |
| pg_result | output | 32 | Word value after the request (old value if refused) |
| pg_conflict | output | 32 | Targeted bits already programmed, valid with the outcome pulse |

## Verification
The assertions assume that rst_n is held low for at least one clock edge. They also assume the consumer does not change rd_rsp_ready in a way that relies on same-edge ordering: inputs change only away from the rising edge. The bench drives every input on the falling edge and samples there. The handshake properties only relate outputs to sampled inputs, so the stimulus may hold a program request valid through a busy period to probe that it is ignored. It drops that request before the engine goes idle, so no unintended transfer follows.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int WORD_W = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [1:0] {
    PG_IDLE   = 2'd0,
    PG_EVAL   = 2'd1,
    PG_COMMIT = 2'd2
  } pg_state_e;

  // One-way update: odd words may only lose ones, even words only gain them.
  function automatic logic [WORD_W-1:0] burn_apply(input logic odd,
                                                   input logic [WORD_W-1:0] old,
                                                   input logic [WORD_W-1:0] sel_n);
    return odd ? (old & sel_n) : (old | ~sel_n);
  endfunction

  // Targeted bits that already sit in their burned state.
  function automatic logic [WORD_W-1:0] burn_overlap(input logic odd,
                                                     input logic [WORD_W-1:0] old,
                                                     input logic [WORD_W-1:0] sel_n);
    return odd ? (~old & ~sel_n) : (old & ~sel_n);
  endfunction

endpackage

// File: rtl/otp_store.sv
module otp_store #(
  parameter int DEPTH = 64,
  parameter int IW    = 7,
  parameter int NRD   = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [IW-1:0]                         wr_idx,
  input  logic [otp_pkg::WORD_W-1:0]            wr_data,
  input  logic [NRD-1:0][IW-1:0]                rd_idx,
  output logic [NRD-1:0][otp_pkg::WORD_W-1:0]   rd_data
);
  localparam int LW = $clog2(DEPTH);
  localparam logic [IW-1:0] DEPTH_I = IW'(DEPTH);

  logic [otp_pkg::WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= (i % 2 == 1) ? '1 : '0;
      end
    end else if (wr_en && (wr_idx < DEPTH_I)) begin
      cells[wr_idx[LW-1:0]] <= wr_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = (rd_idx[g] < DEPTH_I) ? cells[rd_idx[g][LW-1:0]] : '0;
  end

endmodule

// File: rtl/otp_rd_port.sv
module otp_rd_port #(
  parameter int AW = 8,
  parameter int IW = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [AW-1:0]               addr,
  input  logic [1:0]                  size_code,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [otp_pkg::WORD_W-1:0]  rsp_data,
  output logic [IW-1:0]               lo_idx,
  output logic [IW-1:0]               hi_idx,
  input  logic [otp_pkg::WORD_W-1:0]  lo_data,
  input  logic [otp_pkg::WORD_W-1:0]  hi_data
);
  localparam int NB = otp_pkg::WORD_BYTES;

  logic [7:0]                  pool [2*NB];
  logic [otp_pkg::WORD_W-1:0]  picked;
  logic                        take;

  assign lo_idx = {1'b0, addr[AW-1:2]};
  assign hi_idx = lo_idx + IW'(1);

  for (genvar b = 0; b < NB; b++) begin : g_pool
    assign pool[b]      = lo_data[8*b +: 8];
    assign pool[NB + b] = hi_data[8*b +: 8];
  end

  for (genvar k = 0; k < NB; k++) begin : g_pick
    assign picked[8*k +: 8] = (2'(k) <= size_code)
                              ? pool[3'(addr[1:0]) + 3'(k)] : 8'h00;
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= picked;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/otp_prog_engine.sv
module otp_prog_engine #(
  parameter int DEPTH = 64,
  parameter int IW    = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [IW-1:0]               req_idx,
  input  logic [otp_pkg::WORD_W-1:0]  req_mask,
  output logic [IW-1:0]               rd_idx,
  input  logic [otp_pkg::WORD_W-1:0]  rd_data,
  output logic                        wr_en,
  output logic [IW-1:0]               wr_idx,
  output logic [otp_pkg::WORD_W-1:0]  wr_data,
  output logic                        busy,
  output logic                        done,
  output logic                        err,
  output logic [otp_pkg::WORD_W-1:0]  result,
  output logic [otp_pkg::WORD_W-1:0]  conflict
);
  import otp_pkg::*;

  localparam logic [IW-1:0] DEPTH_I = IW'(DEPTH);

  pg_state_e          state_q;
  logic [IW-1:0]      idx_q;
  logic [WORD_W-1:0]  mask_q;
  logic [WORD_W-1:0]  old_q;
  logic               ok_q;
  logic               commit;
  logic [WORD_W-1:0]  burned;

  assign req_ready = (state_q == PG_IDLE);
  assign busy      = (state_q != PG_IDLE);
  assign commit    = (state_q == PG_COMMIT);
  assign rd_idx    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_IDLE;
      idx_q   <= '0;
      mask_q  <= '1;
      old_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      unique case (state_q)
        PG_IDLE: if (req_valid) begin
          idx_q   <= req_idx;
          mask_q  <= req_mask;
          state_q <= PG_EVAL;
        end
        PG_EVAL: begin
          old_q   <= rd_data;
          ok_q    <= (idx_q < DEPTH_I) && ((rd_data ^ ~mask_q) != '0);
          state_q <= PG_COMMIT;
        end
        default: state_q <= PG_IDLE;
      endcase
    end
  end

  assign burned   = burn_apply(idx_q[0], old_q, mask_q);
  assign wr_en    = commit && ok_q;
  assign wr_idx   = idx_q;
  assign wr_data  = burned;
  assign done     = commit && ok_q;
  assign err      = commit && !ok_q;
  assign result   = ok_q ? burned : old_q;
  assign conflict = commit ? burn_overlap(idx_q[0], old_q, mask_q) : '0;

endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_req_valid,
  output logic                          rd_req_ready,
  input  logic [$clog2(DEPTH)+1:0]      rd_addr,
  input  logic [1:0]                    rd_size,
  output logic                          rd_rsp_valid,
  input  logic                          rd_rsp_ready,
  output logic [31:0]                   rd_rsp_data,
  input  logic                          pg_req_valid,
  output logic                          pg_req_ready,
  input  logic [$clog2(DEPTH):0]        pg_index,
  input  logic [31:0]                   pg_mask,
  output logic                          pg_busy,
  output logic                          pg_done,
  output logic                          pg_error,
  output logic [31:0]                   pg_result,
  output logic [31:0]                   pg_conflict
);
  localparam int LW  = $clog2(DEPTH);
  localparam int IW  = LW + 1;
  localparam int AW  = LW + 2;
  localparam int NRD = 3;

  logic [NRD-1:0][IW-1:0] rd_idx;
  logic [NRD-1:0][31:0]   rd_word;
  logic                   wr_en;
  logic [IW-1:0]          wr_idx;
  logic [31:0]            wr_data;

  otp_store #(.DEPTH(DEPTH), .IW(IW), .NRD(NRD)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_word)
  );

  otp_rd_port #(.AW(AW), .IW(IW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .addr      (rd_addr),
    .size_code (rd_size),
    .rsp_valid (rd_rsp_valid),
    .rsp_ready (rd_rsp_ready),
    .rsp_data  (rd_rsp_data),
    .lo_idx    (rd_idx[0]),
    .hi_idx    (rd_idx[1]),
    .lo_data   (rd_word[0]),
    .hi_data   (rd_word[1])
  );

  otp_prog_engine #(.DEPTH(DEPTH), .IW(IW)) u_pg (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (pg_req_valid),
    .req_ready (pg_req_ready),
    .req_idx   (pg_index),
    .req_mask  (pg_mask),
    .rd_idx    (rd_idx[2]),
    .rd_data   (rd_word[2]),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .busy      (pg_busy),
    .done      (pg_done),
    .err       (pg_error),
    .result    (pg_result),
    .conflict  (pg_conflict)
  );

endmodule

// File: rtl/otp_array_chk.sv
module otp_array_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pg_req_valid,
  input logic        pg_req_ready,
  input logic        pg_busy,
  input logic        pg_done,
  input logic        pg_error,
  input logic        rd_rsp_valid,
  input logic        rd_rsp_ready,
  input logic [31:0] rd_rsp_data
);

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pg_req_valid && pg_req_ready |=> pg_busy);

  assert_busy_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_busy) |=> pg_busy);

  assert_outcome_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_done || pg_error) |=> !pg_busy && !pg_done && !pg_error);

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pg_busy |-> !pg_req_ready);

  assert_outcome_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_done && pg_error));

  assert_outcome_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_done || pg_error) |-> pg_busy);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && !rd_rsp_ready |=> rd_rsp_valid && $stable(rd_rsp_data));

endmodule

bind otp_array otp_array_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pg_req_valid (pg_req_valid),
  .pg_req_ready (pg_req_ready),
  .pg_busy      (pg_busy),
  .pg_done      (pg_done),
  .pg_error     (pg_error),
  .rd_rsp_valid (rd_rsp_valid),
  .rd_rsp_ready (rd_rsp_ready),
  .rd_rsp_data  (rd_rsp_data)
);

// File: tb/otp_array_tb.sv
`timescale 1ns/1ps
module otp_array_tb;
  localparam int DEPTH = 64;
  localparam int LW = $clog2(DEPTH);
  localparam int IW = LW + 1;
  localparam int AW = LW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req_valid = 1'b0, rd_req_ready;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0] rd_size = '0;
  logic rd_rsp_valid, rd_rsp_ready = 1'b1;
  logic [31:0] rd_rsp_data;
  logic pg_req_valid = 1'b0, pg_req_ready;
  logic [IW-1:0] pg_index = '0;
  logic [31:0] pg_mask = '1;
  logic pg_busy, pg_done, pg_error;
  logic [31:0] pg_result, pg_conflict;

  otp_array #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .pg_req_valid(pg_req_valid), .pg_req_ready(pg_req_ready),
    .pg_index(pg_index), .pg_mask(pg_mask),
    .pg_busy(pg_busy), .pg_done(pg_done), .pg_error(pg_error),
    .pg_result(pg_result), .pg_conflict(pg_conflict)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [31:0] model [DEPTH];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int addr, input int szc);
    logic [31:0] r = '0;
    for (int k = 0; k <= szc; k++) begin
      int a = addr + k;
      if (a < DEPTH * 4) begin
        logic [31:0] w = model[a / 4] >> (8 * (a % 4));
        r[8*k +: 8] = w[7:0];
      end
    end
    return r;
  endfunction

  task automatic calc(input int idx, input logic [31:0] mask, output bit ok,
                      output logic [31:0] newv, output logic [31:0] res,
                      output logic [31:0] conf);
    bit inr = (idx < DEPTH);
    logic [31:0] old = inr ? model[idx] : 32'h0;
    bit odd = idx[0];
    ok   = inr && ((old ^ ~mask) != 32'h0);
    newv = odd ? (old & mask) : (old | ~mask);
    res  = ok ? newv : old;
    conf = odd ? (~old & ~mask) : (old & ~mask);
  endtask

  task automatic do_read(input string tag, input int addr, input int szc);
    rd_req_valid = 1'b1; rd_addr = AW'(addr); rd_size = 2'(szc); rd_rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_req_valid = 1'b0;
    chk({tag, " R10 rsp valid"}, {31'b0, rd_rsp_valid}, 32'd1);
    chk({tag, " data"}, rd_rsp_data, exp_read(addr, szc));
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_prog(input string tag, input int idx, input logic [31:0] mask);
    bit ok; logic [31:0] newv, res, conf;
    calc(idx, mask, ok, newv, res, conf);
    pg_req_valid = 1'b1; pg_index = IW'(idx); pg_mask = mask;
    @(posedge clk); @(negedge clk);
    pg_req_valid = 1'b0;
    chk("R7 first busy cycle {busy,done,err}", {29'b0, pg_busy, pg_done, pg_error}, 32'b100);
    @(posedge clk); @(negedge clk);
    chk("R7 second busy cycle", {31'b0, pg_busy}, 32'd1);
    chk({tag, " R11 outcome {done,err}"}, {30'b0, pg_done, pg_error}, {30'b0, ok, !ok});
    if (idx < DEPTH) begin
      chk({tag, " result"}, pg_result, res);
      chk("R6 conflict", pg_conflict, conf);
    end
    @(posedge clk); @(negedge clk);
    chk("R7 idle after {busy,done,err}", {29'b0, pg_busy, pg_done, pg_error}, 32'b0);
    if (ok) model[idx] = newv;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R7 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = (i % 2 == 1) ? 32'hFFFF_FFFF : 32'h0;
    repeat (3) @(negedge clk);
    chk("R7 reset {busy,done,err,pg_ready}", {28'b0, pg_busy, pg_done, pg_error, pg_req_ready}, 32'b0001);
    chk("R10 reset rsp_valid", {31'b0, rd_rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset pattern, every word
    for (int w = 0; w < DEPTH; w++) do_read("R1 reset word", 4 * w, 3);

    // R2 / R3 first pass over every word
    for (int w = 0; w < DEPTH; w++)
      do_prog(w[0] ? "R3 odd pass1" : "R2 even pass1", w, 32'h5A5A_5A5A ^ (w * 32'h0103_0507));
    // second pass produces conflicts
    for (int w = 0; w < DEPTH; w++)
      do_prog(w[0] ? "R3 odd pass2" : "R2 even pass2", w, 32'hC3C3_3C3C ^ (w * 32'h1020_4081));
    for (int w = 0; w < DEPTH; w++) do_read("R2 R3 readback", 4 * w, 3);

    // R9: every byte address, every size
    for (int a = 0; a < DEPTH * 4; a++)
      for (int s = 0; s < 4; s++) do_read("R9 unaligned", a, s);

    // R4: refused when word equals inverted mask
    do_prog("R4 even refuse", 2, ~model[2]);
    do_prog("R4 odd refuse", 5, ~model[5]);
    do_read("R4 even unchanged", 8, 3);
    do_read("R4 odd unchanged", 20, 3);

    // R5: index beyond depth
    do_prog("R5 out of range", DEPTH, 32'h0);
    do_prog("R5 out of range top", 2 * DEPTH - 1, 32'h0);
    for (int w = 0; w < 4; w++) do_read("R5 array unchanged", 4 * w, 3);

    // R8: request held during busy is ignored
    begin
      bit ok; logic [31:0] newv, res, conf;
      calc(10, 32'h0F0F_FFFF, ok, newv, res, conf);
      pg_req_valid = 1'b1; pg_index = IW'(10); pg_mask = 32'h0F0F_FFFF;
      @(posedge clk); @(negedge clk);
      pg_index = IW'(11); pg_mask = 32'h0;
      chk("R8 ready low busy cycle 1", {31'b0, pg_req_ready}, 32'd0);
      @(posedge clk); @(negedge clk);
      chk("R8 ready low busy cycle 2", {31'b0, pg_req_ready}, 32'd0);
      chk("R8 first request outcome", {30'b0, pg_done, pg_error}, {30'b0, ok, !ok});
      pg_req_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      if (ok) model[10] = newv;
      do_read("R8 ignored word unchanged", 44, 3);
      do_read("R2 word written", 40, 3);
    end

    // R10: response back-pressure
    begin
      logic [31:0] held;
      rd_rsp_ready = 1'b0; rd_req_valid = 1'b1; rd_addr = AW'(6); rd_size = 2'd3;
      @(posedge clk); @(negedge clk);
      rd_req_valid = 1'b0;
      held = rd_rsp_data;
      chk("R10 stalled data", held, exp_read(6, 3));
      for (int c = 0; c < 3; c++) begin
        @(posedge clk); @(negedge clk);
        chk("R10 stalled valid", {31'b0, rd_rsp_valid}, 32'd1);
        chk("R10 stalled stable", rd_rsp_data, held);
        chk("R10 req blocked", {31'b0, rd_req_ready}, 32'd0);
      end
      rd_rsp_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R10 drained", {31'b0, rd_rsp_valid}, 32'd0);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule